// File: doc/BRIEF.md
# PWM Compare Shadow Controller

The block is the register and compare front end of a two-waveform PWM timer. A byte-wide write port loads the set and clear compare points of waveforms A and B into shadow registers. A load request copies all four shadow values into the active compare registers at once, at the end of the current timer period, so a waveform never runs on a half-updated pair of values. The request can come from an explicit strobe or from the write of a high byte.

A free-running 12-bit counter runs from zero up to a programmable top value and then wraps. The wrap marks the end of the period. Each waveform rises on its set match and falls on its clear match. A mode register can mirror waveform B compare writes into waveform A. It can also route either waveform to the two extra outputs C and D, and it can force both waveforms to software-chosen levels.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset the mode, override, shadow and active registers and the counter are all zero, the top value is all ones, and every PWM output is low while reset is held.
- R2: The counter steps by one each clock and returns to 0 on the clock after it equals the top value. `cycle_end_o` is high for exactly the cycle in which the counter equals the top value. The top value's low byte is at address 0xC and its high nibble is at 0xD.
- R3: A waveform goes high on the clock after the counter equals its active set value. It goes low on the clock after the counter equals its active clear value. When both values match, set wins.
- R4: Shadow writes have no effect on the waveforms until a load. A load happens only on a clock where a request is pending and `cycle_end_o` is high, and it copies all four shadow values together. The shadow registers are at these addresses: A set 0x4/0x5, A clear 0x6/0x7, B set 0x8/0x9, B clear 0xA/0xB, with the low byte at the even address and the high nibble at the odd one.
- R5: Low-byte writes never raise a request. A write to the A clear high byte raises no request unless both auto-load and mirror mode are set.
- R6: With auto-load set (mode bit 1, mode register at 0x0), a write to the B clear high byte raises a request.
- R7: With mirror mode set (mode bit 3), every write to a B set or B clear byte also goes into the matching A byte. Writes to A bytes never change B.
- R8: With mirror mode and auto-load both set, a write to the A clear high byte raises a request.
- R9: Writing 1 to bit 0 at address 0x2 raises a request regardless of auto-load.
- R10: A request raised on the clock where the counter equals the top value is not serviced by that wrap. It stays pending until the next period end.
- R11: Mode bit 6 selects the source of output C and mode bit 7 selects the source of output D. A value of 0 selects waveform A and a value of 1 selects waveform B.
- R12: With override set (mode bit 0), waveform A is driven from override bit 0 and waveform B from override bit 1 (override register at 0x1). Outputs C and D follow the overridden waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| cnt_o | output | 12 | Timer counter value |
| cycle_end_o | output | 1 | High while the counter equals the top value |
| pwm_a_o | output | 1 | Waveform A |
| pwm_b_o | output | 1 | Waveform B |
| pwm_c_o | output | 1 | Output C, waveform A or B |
| pwm_d_o | output | 1 | Output D, waveform A or B |

## Verification
The hardest case to reach is a load request that lands on the very clock where the counter sits at its top value. The bench waits, at the falling edge, until `cnt_o` reads the top value. It then drives the strobe write so that the write and the wrap share one rising edge. It then checks that the waveform still follows the old compare values through the whole next period and only changes after the following wrap. Checks on pending loads are made at a counter value where the old and new compare pairs give different levels, so a load that comes too early or too late shows at the pins.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_CMP  = 4;

  localparam logic [ADDR_W-1:0] ADR_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_OVR  = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_SYNC = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_CMP0 = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_TOPL = 4'hC;
  localparam logic [ADDR_W-1:0] ADR_TOPH = 4'hD;

  // compare slots: 0 A set, 1 A clr, 2 B set, 3 B clr
  typedef struct packed {
    logic sel_d;
    logic sel_c;
    logic mirror;
    logic auto_ld;
    logic ovr_en;
  } mode_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned    CW      = 12,
  parameter logic [CW-1:0]  TOP_RST = {CW{1'b1}}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       cyc_end_i,
  output mode_t                      mode_o,
  output logic [1:0]                 ovr_o,
  output logic [CW-1:0]              top_o,
  output logic [N_CMP-1:0][CW-1:0]   act_o
);
  localparam int unsigned HW = CW - 8;

  logic [N_CMP-1:0][CW-1:0] shd_q, act_q;
  logic [N_CMP-1:0]         lo_hit, hi_hit, lo_we, hi_we;
  mode_t                    mode_q;
  logic [1:0]               ovr_q;
  logic [CW-1:0]            top_q;
  logic                     pend_q, req, load, sync_hit;

  always_comb begin
    for (int i = 0; i < N_CMP; i++) begin
      lo_hit[i] = wr_en_i && (addr_i == ADDR_W'(32'(ADR_CMP0) + 32'(2 * i)));
      hi_hit[i] = wr_en_i && (addr_i == ADDR_W'(32'(ADR_CMP0) + 32'(2 * i + 1)));
    end
    // mirror mode: B slots also land in A slots
    lo_we = lo_hit | (mode_q.mirror ? {2'b00, lo_hit[3:2]} : '0);
    hi_we = hi_hit | (mode_q.mirror ? {2'b00, hi_hit[3:2]} : '0);
    sync_hit = wr_en_i && (addr_i == ADR_SYNC) && wdata_i[0];
    req  = sync_hit
         | (hi_hit[3] & mode_q.auto_ld)
         | (hi_hit[1] & mode_q.auto_ld & mode_q.mirror);
    load = pend_q & cyc_end_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ovr_q  <= '0;
      top_q  <= TOP_RST;
      shd_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADR_MODE)
        mode_q <= '{sel_d: wdata_i[7], sel_c: wdata_i[6], mirror: wdata_i[3],
                    auto_ld: wdata_i[1], ovr_en: wdata_i[0]};
      if (wr_en_i && addr_i == ADR_OVR)  ovr_q        <= wdata_i[1:0];
      if (wr_en_i && addr_i == ADR_TOPL) top_q[7:0]   <= wdata_i;
      if (wr_en_i && addr_i == ADR_TOPH) top_q[CW-1:8] <= wdata_i[HW-1:0];
      for (int i = 0; i < N_CMP; i++) begin
        if (lo_we[i]) shd_q[i][7:0]    <= wdata_i;
        if (hi_we[i]) shd_q[i][CW-1:8] <= wdata_i[HW-1:0];
      end
      // a request on the wrap clock waits for the next wrap
      pend_q <= req | (pend_q & ~cyc_end_i);
      if (load) act_q <= shd_q;
    end
  end

  assign mode_o = mode_q;
  assign ovr_o  = ovr_q;
  assign top_o  = top_q;
  assign act_o  = act_q;

  assert_active_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_i |=> $stable(act_q));
  assert_req_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> pend_q);
  assert_pend_served_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cyc_end_i && !req) |=> !pend_q);
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o,
  output logic          cyc_end_o
);
  logic [CW-1:0] cnt_q;

  assign cyc_end_o = (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cyc_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end_o |=> cnt_q == '0);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_o |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/pwm_wave_gen.sv
`timescale 1ns/1ps
module pwm_wave_gen #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] set_i,
  input  logic [CW-1:0] clr_i,
  output logic          wave_o
);
  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wave_q <= 1'b0;
    else if (cnt_i == set_i)  wave_q <= 1'b1;
    else if (cnt_i == clr_i)  wave_q <= 1'b0;
  end

  assign wave_o = wave_q;

  assert_set_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == set_i) |=> wave_o);
  assert_clr_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == clr_i && cnt_i != set_i) |=> !wave_o);
endmodule

// File: rtl/pwm_out_map.sv
`timescale 1ns/1ps
module pwm_out_map
  import pwm_shadow_pkg::*;
(
  input  mode_t      mode_i,
  input  logic [1:0] ovr_i,
  input  logic [1:0] wave_i,
  output logic       pwm_a_o,
  output logic       pwm_b_o,
  output logic       pwm_c_o,
  output logic       pwm_d_o
);
  logic [1:0] lvl;

  assign lvl     = mode_i.ovr_en ? ovr_i : wave_i;
  assign pwm_a_o = lvl[0];
  assign pwm_b_o = lvl[1];
  assign pwm_c_o = mode_i.sel_c ? lvl[1] : lvl[0];
  assign pwm_d_o = mode_i.sel_d ? lvl[1] : lvl[0];
endmodule

// File: rtl/pwm_shadow_ctrl.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned   CW      = 12,
  parameter logic [CW-1:0] TOP_RST = {CW{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [CW-1:0]     cnt_o,
  output logic              cycle_end_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              pwm_c_o,
  output logic              pwm_d_o
);
  mode_t                    mode;
  logic [1:0]               ovr, wave;
  logic [CW-1:0]            top, cnt;
  logic [N_CMP-1:0][CW-1:0] act;
  logic                     cyc_end;

  pwm_shadow_regs #(.CW(CW), .TOP_RST(TOP_RST)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cyc_end_i(cyc_end), .mode_o(mode), .ovr_o(ovr), .top_o(top), .act_o(act)
  );

  pwm_timebase #(.CW(CW)) tb_i (
    .clk_i, .rst_ni, .top_i(top), .cnt_o(cnt), .cyc_end_o(cyc_end)
  );

  for (genvar g = 0; g < 2; g++) begin : g_wave
    pwm_wave_gen #(.CW(CW)) wave_i (
      .clk_i, .rst_ni, .cnt_i(cnt),
      .set_i(act[2*g]), .clr_i(act[2*g+1]), .wave_o(wave[g])
    );
  end

  pwm_out_map map_i (
    .mode_i(mode), .ovr_i(ovr), .wave_i(wave),
    .pwm_a_o, .pwm_b_o, .pwm_c_o, .pwm_d_o
  );

  assign cnt_o       = cnt;
  assign cycle_end_o = cyc_end;
endmodule

// File: tb/pwm_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl_tb_top;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [CW-1:0] cnt;
  logic          cyc_end, pa, pb, pc, pd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    sig;
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  pwm_shadow_ctrl #(.CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .cnt_o(cnt), .cycle_end_o(cyc_end),
    .pwm_a_o(pa), .pwm_b_o(pb), .pwm_c_o(pc), .pwm_d_o(pd)
  );

  function automatic int peek(int s);
    case (s)
      0: return int'(cnt);
      1: return int'(pa);
      2: return int'(pb);
      3: return int'(pc);
      4: return int'(pd);
      default: return int'(cyc_end);
    endcase
  endfunction

  function automatic string sname(int s);
    case (s)
      0: return "cnt";
      1: return "pwm_a";
      2: return "pwm_b";
      3: return "pwm_c";
      4: return "pwm_d";
      default: return "cycle_end";
    endcase
  endfunction

  // monitor: compares queued items 1 ns after the falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (peek(it.sig) != it.exp) begin
        errors++;
        $display("FAIL %s %s actual %0d expected %0d at cnt %0d",
                 it.tag, sname(it.sig), peek(it.sig), it.exp, cnt);
      end
    end
  end

  task automatic expect_v(int s, int e, string tag);
    item_t it;
    it.sig = s; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // callers sit at a falling edge
  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(int v);
    do @(negedge clk); while (int'(cnt) != v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_v(0, 0, "R1"); expect_v(1, 0, "R1"); expect_v(2, 0, "R1");
    expect_v(3, 0, "R1"); expect_v(4, 0, "R1"); expect_v(5, 0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // top = 9, ten-clock period
    wr(4'hC, 8'd9);
    wr(4'hD, 8'd0);
    wait_cnt(9);
    expect_v(5, 1, "R2 cycle end at top");
    @(negedge clk);
    expect_v(0, 0, "R2 wrap to zero");
    expect_v(5, 0, "R2 cycle end low");
    @(negedge clk);
    expect_v(0, 1, "R2 step");
    wait_cnt(5);
    expect_v(1, 1, "R3 set wins"); expect_v(2, 1, "R3 set wins");

    // R5: auto on, low bytes and A clr high without mirror raise nothing
    wr(4'h0, 8'h02);
    wr(4'h4, 8'd2);
    wr(4'h6, 8'd6);
    wr(4'h7, 8'd0);
    wr(4'hA, 8'd5);
    wait_cnt(0); wait_cnt(0); wait_cnt(8);
    expect_v(1, 1, "R5 no request");
    expect_v(2, 1, "R5 no request");

    // R6/R4: B clr high write with auto, serviced at next wrap
    wait_cnt(1);
    wr(4'hB, 8'd0);
    wait_cnt(8);
    expect_v(1, 1, "R4 load waits for wrap");
    wait_cnt(0); wait_cnt(8);
    expect_v(1, 0, "R6 auto load A");
    wait_cnt(4);
    expect_v(1, 1, "R3 A high between set and clr");
    wait_cnt(3);
    expect_v(2, 1, "R4 B loaded");
    wait_cnt(8);
    expect_v(2, 0, "R4 B loaded");

    // R11 routing
    wr(4'h0, 8'h82);
    wait_cnt(6);
    expect_v(1, 1, "R11"); expect_v(2, 0, "R11");
    expect_v(3, 1, "R11 C=A"); expect_v(4, 0, "R11 D=B");
    wr(4'h0, 8'h42);
    wait_cnt(6);
    expect_v(3, 0, "R11 C=B"); expect_v(4, 1, "R11 D=A");

    // R12 override
    wr(4'h1, 8'h02);
    wr(4'h0, 8'h01);
    wait_cnt(4);
    expect_v(1, 0, "R12"); expect_v(2, 1, "R12"); expect_v(3, 0, "R12 C follows");
    wait_cnt(8);
    expect_v(1, 0, "R12"); expect_v(2, 1, "R12");
    wr(4'h1, 8'h01);
    wait_cnt(8);
    expect_v(1, 1, "R12"); expect_v(2, 0, "R12");
    wr(4'h0, 8'h00);
    wait_cnt(4);
    expect_v(1, 1, "R12 released"); expect_v(2, 1, "R12 released");

    // R7 mirror with auto
    wr(4'h0, 8'h0A);
    wr(4'h8, 8'd1);
    wr(4'h9, 8'd0);
    wr(4'hA, 8'd7);
    wr(4'hB, 8'd0);
    wait_cnt(0); wait_cnt(0); wait_cnt(7);
    expect_v(1, 1, "R7 mirror"); expect_v(2, 1, "R7");
    wait_cnt(9);
    expect_v(1, 0, "R7 mirror"); expect_v(2, 0, "R7");

    // R8: A clr high with mirror+auto requests; B untouched
    wr(4'h6, 8'd4);
    wr(4'h7, 8'd0);
    wait_cnt(0); wait_cnt(0); wait_cnt(6);
    expect_v(1, 0, "R8 A clr load");
    expect_v(2, 1, "R7 A write leaves B");

    // R9 strobe with auto off
    wr(4'h0, 8'h00);
    wr(4'h4, 8'd5);
    wr(4'h2, 8'h01);
    wait_cnt(0); wait_cnt(0); wait_cnt(8);
    expect_v(1, 1, "R9 strobe load");

    // R10 strobe on the wrap clock
    wr(4'h4, 8'd1);
    wait_cnt(9);
    wr(4'h2, 8'h01);
    wait_cnt(8);
    expect_v(1, 1, "R10 not this wrap");
    wait_cnt(8);
    expect_v(1, 0, "R10 next wrap");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule